// File: doc/BRIEF.md
# Tree-Walk Multi-Branch Direction Predictor

This block predicts the directions of up to four consecutive conditional branches in a single cycle. A wide fetch unit or a block-based trace cache can then deliver several basic blocks per fetch. A lookup presents the address of the first block. The same cycle, the block returns a direction vector with one bit per branch, a count of how many of those bits are meaningful, and the global history value used for the prediction. The fetch side keeps that history value with the fetch group and hands it back when the group completes.

**How a prediction is formed**

- The start address is hashed to select one tree entry.
- Each entry is a binary tree of fifteen node predictors, arranged in four levels.
- Each node owns a pattern table of 2-bit saturating counters, indexed by the global history register.
- The first-level node gives the first direction. Each predicted direction then selects the left or right child, which supplies the next direction.

**How training works**

Training happens at completion, not at fetch. A completion update carries:

- the start address,
- the history that was used at lookup,
- the number of resolved branches,
- their actual outcomes.

Only the nodes on the path that actually executed are trained. The global history is then rebuilt from the returned history plus the resolved outcomes. This also corrects any history that speculative use had left stale.

**Handshakes**

Both the lookup and the update channel are valid/ready. The block never applies back-pressure: `lk_ready` and `up_ready` are held high outside reset as well as during it. A lookup is answered combinationally in the cycle in which `lk_valid` is high. An update is absorbed at the rising clock edge of the cycle in which `up_valid` is high. A producer may therefore issue one lookup and one update every cycle.

Top module: `mbp_tree_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken), the global history is 0, and every tree entry's learned branch count is 1. A first lookup therefore returns direction 0, count 1 and history 0.
- R2: `lk_ready` and `up_ready` are always 1. While `lk_valid` is 0, `lk_dir` and `lk_cnt` are 0.
- R3: The tree entry is selected by `addr[4:2] XOR addr[7:5]`. Two addresses with equal hash share one entry and get identical predictions.
- R4: Node numbering is breadth-first. At level i (0 to 3) the node used is `2^i - 1 + p`, where `p` packs the directions already chosen at levels 0..i-1, with the level-0 direction as the most significant bit. That node's counter is read at row `lk_hist`, and the direction is taken (1) when the counter is 2 or 3. `lk_dir` bit i holds the level-i direction.
- R5: `lk_cnt` equals the branch count of the most recent accepted update to the same entry, or 1 if there was none. Bits of `lk_dir` at positions at or above `lk_cnt` read 0.
- R6: An accepted update with count c trains only the c nodes on the actual path. The path is formed as in R4 from `up_taken` bit i, the outcome of branch i. Training happens at row `up_hist`. Each counter is incremented on taken and decremented on not-taken, and saturates at 0 and 3.
- R7: After an accepted update, the history becomes `up_hist` shifted left once per resolved branch, branch 0 first, with each outcome entering at bit 0, truncated to 3 bits. Without an accepted update the history holds.
- R8: When a lookup and an update fall in the same cycle, the lookup sees the counters, count and history as they were before that update.
- R9: An update whose count is 0 or greater than 4 is ignored. It changes no counter, no learned count and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_addr | input | 32 | Start block address of the lookup |
| lk_dir | output | 4 | Predicted directions, bit i = branch i, 1 = taken |
| lk_cnt | output | 3 | Number of valid direction bits (1 to 4; 0 when idle) |
| lk_hist | output | 3 | Global history used for this lookup |
| up_valid | input | 1 | Completion update present |
| up_ready | output | 1 | Update accepted (always 1) |
| up_addr | input | 32 | Start block address of the completed group |
| up_hist | input | 3 | History that was returned at lookup time |
| up_cnt | input | 3 | Number of resolved branches (1 to 4 legal) |
| up_taken | input | 4 | Actual outcomes, bit i = branch i |

## Verification
A lookup and a completion update can land in the same cycle, including on the same tree entry. That case decides whether the prediction reads counters, count and history before or after training. The bench provokes it in two ways:

- a directed phase that issues a lookup and an update to one address together, and
- a long random phase with a small address space, where such collisions are frequent.

A behavioural model in the bench computes the expected outputs from its pre-update state in every cycle, then applies the update. Any lookup that reflects the new state in the same cycle therefore shows up as a direction, count or history mismatch.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;

  // saturating 2-bit step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == 2'd3) ? c : c + 2'd1;
    else       r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/mbp_index_hash.sv
module mbp_index_hash #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 3,
  parameter int ADDR_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int HI_LSB = ADDR_LSB + 2*IDX_W;

  logic unused_low;
  logic unused_high;

  assign unused_low  = ^addr[ADDR_LSB-1:0];
  assign unused_high = ^addr[ADDR_W-1:HI_LSB];

  assign idx = addr[ADDR_LSB +: IDX_W] ^ addr[ADDR_LSB+IDX_W +: IDX_W];
endmodule

// File: rtl/mbp_node_table.sv
module mbp_node_table
  import mbp_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_entry,
  input  logic [HIST_W-1:0] rd_hist,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_entry,
  input  logic [HIST_W-1:0] wr_hist,
  input  logic              wr_taken
);
  localparam int AW    = IDX_W + HIST_W;
  localparam int SLOTS = 1 << AW;

  ctr_t          mem [SLOTS];
  logic [AW-1:0] rd_a;
  logic [AW-1:0] wr_a;

  assign rd_a   = {rd_entry, rd_hist};
  assign wr_a   = {wr_entry, wr_hist};
  assign rd_ctr = mem[rd_a];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) mem[s] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_a] <= ctr_step(mem[wr_a], wr_taken);
    end
  end
endmodule

// File: rtl/mbp_tree_walk.sv
module mbp_tree_walk
  import mbp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic [2*((1<<DEPTH)-1)-1:0] ctrs_flat,
  output logic [DEPTH-1:0]            dir
);
  localparam int NODES = (1 << DEPTH) - 1;
  localparam int NW    = $clog2(NODES);

  always_comb begin
    logic [DEPTH-1:0] path;
    logic [NW-1:0]    node;
    ctr_t             c;
    path = '0;
    dir  = '0;
    for (int lvl = 0; lvl < DEPTH; lvl++) begin
      node     = NW'((1 << lvl) - 1) + NW'(path);
      c        = ctrs_flat[2*node +: 2];
      dir[lvl] = ctr_says_taken(c);
      path     = {path[DEPTH-2:0], dir[lvl]};
    end
  end
endmodule

// File: rtl/mbp_hist_reg.sv
module mbp_hist_reg #(
  parameter int HIST_W = 3,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [HIST_W-1:0] base_hist,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DEPTH-1:0]  taken,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] rebuilt;

  always_comb begin
    rebuilt = base_hist;
    for (int b = 0; b < DEPTH; b++) begin
      if (CNT_W'(b) < cnt) rebuilt = {rebuilt[HIST_W-2:0], taken[b]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hist <= '0;
    else if (upd_en) hist <= rebuilt;
  end
endmodule

// File: rtl/mbp_tree_predictor.sv
module mbp_tree_predictor
  import mbp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 3,
  parameter int ADDR_LSB = 2,
  parameter int HIST_W   = 3,
  parameter int DEPTH    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  output logic                        lk_ready,
  input  logic [ADDR_W-1:0]           lk_addr,
  output logic [DEPTH-1:0]            lk_dir,
  output logic [$clog2(DEPTH+1)-1:0]  lk_cnt,
  output logic [HIST_W-1:0]           lk_hist,
  input  logic                        up_valid,
  output logic                        up_ready,
  input  logic [ADDR_W-1:0]           up_addr,
  input  logic [HIST_W-1:0]           up_hist,
  input  logic [$clog2(DEPTH+1)-1:0]  up_cnt,
  input  logic [DEPTH-1:0]            up_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NODES   = (1 << DEPTH) - 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]     lk_entry;
  logic [IDX_W-1:0]     up_entry;
  logic [HIST_W-1:0]    ghr;
  logic [2*NODES-1:0]   node_ctrs;
  logic [DEPTH-1:0]     walk_dir;
  logic [DEPTH-1:0]     cnt_mask;
  logic [CNT_W-1:0]     cnt_tab [ENTRIES];
  logic [DEPTH-1:0]     up_prefix [DEPTH];
  logic                 up_legal;
  logic                 up_fire;

  assign lk_ready = 1'b1;
  assign up_ready = 1'b1;

  assign up_legal = (up_cnt != '0) && (up_cnt <= CNT_W'(DEPTH));
  assign up_fire  = up_valid && up_legal;

  mbp_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ADDR_LSB(ADDR_LSB)) u_lk_hash (
    .addr (lk_addr),
    .idx  (lk_entry)
  );

  mbp_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ADDR_LSB(ADDR_LSB)) u_up_hash (
    .addr (up_addr),
    .idx  (up_entry)
  );

  // actual-path prefix per level, branch 0 most significant
  always_comb begin
    up_prefix[0] = '0;
    for (int l = 1; l < DEPTH; l++) up_prefix[l] = {up_prefix[l-1][DEPTH-2:0], up_taken[l-1]};
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int LVL = $clog2(n + 2) - 1;
    localparam int OFF = n - ((1 << LVL) - 1);
    logic on_path;
    ctr_t rd_c;

    assign on_path = up_fire && (CNT_W'(LVL) < up_cnt) && (up_prefix[LVL] == DEPTH'(OFF));

    mbp_node_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_entry (lk_entry),
      .rd_hist  (ghr),
      .rd_ctr   (rd_c),
      .wr_en    (on_path),
      .wr_entry (up_entry),
      .wr_hist  (up_hist),
      .wr_taken (up_taken[LVL])
    );

    assign node_ctrs[2*n +: 2] = rd_c;
  end

  mbp_tree_walk #(.DEPTH(DEPTH)) u_walk (
    .ctrs_flat (node_ctrs),
    .dir       (walk_dir)
  );

  mbp_hist_reg #(.HIST_W(HIST_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (up_fire),
    .base_hist (up_hist),
    .cnt       (up_cnt),
    .taken     (up_taken),
    .hist      (ghr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) cnt_tab[e] <= CNT_W'(1);
    end else if (up_fire) begin
      cnt_tab[up_entry] <= up_cnt;
    end
  end

  always_comb begin
    for (int b = 0; b < DEPTH; b++) cnt_mask[b] = (CNT_W'(b) < cnt_tab[lk_entry]);
  end

  assign lk_dir  = lk_valid ? (walk_dir & cnt_mask) : '0;
  assign lk_cnt  = lk_valid ? cnt_tab[lk_entry] : '0;
  assign lk_hist = ghr;
endmodule

// File: rtl/mbp_tree_predictor_chk.sv
module mbp_tree_predictor_chk #(
  parameter int HIST_W = 3,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [DEPTH-1:0]  lk_dir,
  input logic [CNT_W-1:0]  lk_cnt,
  input logic [HIST_W-1:0] lk_hist,
  input logic              up_valid,
  input logic              up_ready,
  input logic [HIST_W-1:0] up_hist,
  input logic [CNT_W-1:0]  up_cnt,
  input logic [DEPTH-1:0]  up_taken
);
  logic legal_upd;
  assign legal_upd = up_valid && (up_cnt != '0) && (up_cnt <= CNT_W'(DEPTH));

  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready && up_ready);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (lk_dir == '0) && (lk_cnt == '0));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_cnt != '0) && (lk_cnt <= CNT_W'(DEPTH)));

  // R5
  dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ((lk_dir >> lk_cnt) == '0));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_upd |=> $stable(lk_hist));

  // R7
  hist_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_cnt == CNT_W'(1)) |=>
      lk_hist == {$past(up_hist[HIST_W-2:0]), $past(up_taken[0])});
endmodule

bind mbp_tree_predictor mbp_tree_predictor_chk #(
  .HIST_W (HIST_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .lk_dir   (lk_dir),
  .lk_cnt   (lk_cnt),
  .lk_hist  (lk_hist),
  .up_valid (up_valid),
  .up_ready (up_ready),
  .up_hist  (up_hist),
  .up_cnt   (up_cnt),
  .up_taken (up_taken)
);

// File: tb/tb_mbp_tree_predictor.sv
module tb_mbp_tree_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic        lk_ready;
  logic [31:0] lk_addr;
  logic [3:0]  lk_dir;
  logic [2:0]  lk_cnt;
  logic [2:0]  lk_hist;
  logic        up_valid;
  logic        up_ready;
  logic [31:0] up_addr;
  logic [2:0]  up_hist;
  logic [2:0]  up_cnt;
  logic [3:0]  up_taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ctr [8][15][8];
  int m_cnt [8];
  int m_ghr;

  always #4 clk = ~clk;

  mbp_tree_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_dir(lk_dir), .lk_cnt(lk_cnt), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_hist(up_hist), .up_cnt(up_cnt), .up_taken(up_taken)
  );

  function automatic int hash_of(input logic [31:0] a);
    return int'((a >> 2) & 32'd7) ^ int'((a >> 5) & 32'd7);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a negedge: drive, compare against model pre-update state, then advance model
  task automatic cyc(input string ph, input bit lv, input logic [31:0] la,
                     input bit uv, input logic [31:0] ua, input int uh,
                     input int uc, input int ut);
    int e, path, node, d, edir, ecnt, t, g;
    lk_valid = lv; lk_addr = la;
    up_valid = uv; up_addr = ua; up_hist = uh[2:0]; up_cnt = uc[2:0]; up_taken = ut[3:0];
    #1;
    edir = 0; ecnt = 0;
    if (lv) begin
      e = hash_of(la); path = 0;
      for (int l = 0; l < 4; l++) begin
        node = (1 << l) - 1 + path;
        d = (m_ctr[e][node][m_ghr] >= 2) ? 1 : 0;
        if (l < m_cnt[e]) edir |= d << l;
        path = path * 2 + d;
      end
      ecnt = m_cnt[e];
    end
    chk({ph, " R4 dir"}, int'(lk_dir), edir);
    chk({ph, " R5 cnt"}, int'(lk_cnt), ecnt);
    chk({ph, " R7 hist"}, int'(lk_hist), m_ghr);
    chk({ph, " R2 ready"}, int'({lk_ready, up_ready}), 3);
    if (uv && uc >= 1 && uc <= 4) begin
      e = hash_of(ua); path = 0; g = uh & 7;
      for (int l = 0; l < uc; l++) begin
        node = (1 << l) - 1 + path;
        t = (ut >> l) & 1;
        if (t == 1 && m_ctr[e][node][uh & 7] < 3) m_ctr[e][node][uh & 7]++;
        if (t == 0 && m_ctr[e][node][uh & 7] > 0) m_ctr[e][node][uh & 7]--;
        path = path * 2 + t;
        g = ((g << 1) | t) & 7;
      end
      m_cnt[e] = uc;
      m_ghr = g;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 8; e++) begin
      m_cnt[e] = 1;
      for (int n = 0; n < 15; n++)
        for (int h = 0; h < 8; h++) m_ctr[e][n][h] = 1;
    end
    m_ghr = 0;
    rst_n = 0; lk_valid = 0; lk_addr = 0; up_valid = 0; up_addr = 0;
    up_hist = 0; up_cnt = 0; up_taken = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state seen through lookups
    cyc("R1 reset", 1, 32'h0000_0040, 0, 0, 0, 0, 0);
    cyc("R1 reset", 1, 32'h0000_1234, 0, 0, 0, 0, 0);
    // R2: idle lookup outputs zero
    cyc("R2 idle", 0, 32'h0000_1234, 0, 0, 0, 0, 0);

    // R3/R4: train entry 0 via 0x100, observe through alias 0x24
    for (int k = 0; k < 3; k++) cyc("R4 train", 0, 0, 1, 32'h100, 0, 4, 4'b1011);
    for (int k = 0; k < 8; k++) begin
      cyc("R3 alias", 1, 32'h24, 1, 32'h100, k, 4, 4'b1011);
      cyc("R3 alias", 1, 32'h100, 0, 0, 0, 0, 0);
    end

    // R6: saturation at both ends
    for (int k = 0; k < 6; k++) cyc("R6 sat up", 1, 32'h4, 1, 32'h4, 5, 4, 4'b1111);
    for (int k = 0; k < 7; k++) cyc("R6 sat dn", 1, 32'h4, 1, 32'h4, 5, 4, 4'b0000);
    for (int k = 0; k < 3; k++) cyc("R6 sat up", 1, 32'h4, 1, 32'h4, 5, 2, 4'b0011);

    // R5: learned counts 1..4
    for (int c = 1; c <= 4; c++) begin
      cyc("R5 count", 0, 0, 1, 32'h8, 2, c, 4'b0101);
      cyc("R5 count", 1, 32'h8, 0, 0, 0, 0, 0);
    end

    // R8: same-cycle lookup and update to one entry
    for (int k = 0; k < 6; k++) cyc("R8 same cyc", 1, 32'h10, 1, 32'h10, int'(lk_hist), 3, 4'b0111);

    // R9: illegal counts ignored
    cyc("R9 illegal", 1, 32'h10, 1, 32'h10, 6, 0, 4'b1111);
    cyc("R9 illegal", 1, 32'h10, 1, 32'h10, 6, 5, 4'b1111);
    cyc("R9 illegal", 1, 32'h10, 1, 32'h10, 6, 7, 4'b1111);
    cyc("R9 illegal", 1, 32'h10, 0, 0, 0, 0, 0);

    // mixed random traffic, small address space for frequent collisions
    for (int k = 0; k < 4000; k++) begin
      cyc("R8 random", bit'($urandom_range(0, 3) != 0), 32'($urandom_range(0, 255)),
          bit'($urandom_range(0, 1)), 32'($urandom_range(0, 255)),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 5)), int'($urandom_range(0, 15)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule